// File: doc/BRIEF.md
# Counter-Increment-Modifier Index Register File

This block holds a bank of index registers. Each register packs three 16-bit fields: a loop counter, a step (increment) and an address offset (modifier). The modifier of the selected register is always presented for address indexing, together with a flag that shows whether the selected counter is zero. One register operation can be issued per clock. Operations include the post-access update used by auto-stepping memory references, arithmetic on single fields, loads from a 48-bit operand, and copies of any mix of fields from one register into another.

The surrounding datapath decodes instructions, performs the memory access and owns the operand stack. It drives `op_en` with an operation code, a source select `sel_q`, a destination select `sel_qd` used only by copies, and a 48-bit operand `wr_data`. This is a control-side block with no streaming payload, so there is no valid/ready pair. Every enabled operation is accepted on the clock edge where it is presented, and no back-pressure exists. All reads are combinational on `sel_q` and `rd_field`.

Top module: `idx_regfile`

## Requirements
- R1: There are 16 registers, each with three 16-bit fields. `rd_data` shows register `sel_q` combinationally. When `rd_field`=3 it shows the whole register, with the counter in bits 47:32, the increment in 31:16 and the modifier in 15:0. When `rd_field` is 0, 1 or 2 it shows the counter, the increment or the modifier alone, zero-extended to 48 bits.
- R2: Register 0 reads as zero in every field, and no operation changes it.
- R3: Op 1 (post-update) decrements the counter of register `sel_q` by one and adds its increment to its modifier, in a single edge.
- R4: Op 2 adds the increment of register `sel_q` to its modifier. Op 3 subtracts it.
- R5: Op 4 replaces the counter of `sel_q` with its two's-complement negation. Op 5 decrements that counter by one.
- R6: Ops 6, 7, 8 and 9 set the increment of `sel_q` to +1, -1, +2 and -2.
- R7: Ops 10, 11 and 12 load `wr_data[15:0]` into the counter, the increment or the modifier of `sel_q`. Op 13 loads the whole register from `wr_data`, using the R1 layout.
- R8: Ops 14, 15 and 16 first set `sel_q` to counter 0, increment 1 and modifier 0. They then load `wr_data[15:0]` into the counter, the increment or the modifier.
- R9: Ops 17 to 23 copy fields from `sel_q` into `sel_qd`. The fields copied are: 17 counter; 18 increment; 19 modifier; 20 counter and increment; 21 counter and modifier; 22 increment and modifier; 23 all three. Fields that are not copied keep their values.
- R10: Ops 24, 25 and 26 add `wr_data[15:0]` to the counter, the increment or the modifier of `sel_q`. Op 27 adds each 16-bit slice of `wr_data`, taken in the R1 layout, to its own field. No carry passes between fields.
- R11: All field arithmetic wraps modulo 2^16, and no overflow is signalled. `mod_out` is the modifier of `sel_q`. `cnt_zero` is high exactly when the counter of `sel_q` is zero. Both are combinational.
- R12: Reset (`rst_n` low) clears every register to zero. While `op_en` is low, no register changes. Op codes 0 and 28 to 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Apply `op_code` at this edge |
| op_code | input | 5 | Operation code (see requirements) |
| sel_q | input | 4 | Source register and read select |
| sel_qd | input | 4 | Destination register for copies |
| wr_data | input | 48 | Operand from the top of the stack |
| rd_field | input | 2 | Read view: 0 counter, 1 increment, 2 modifier, 3 whole |
| mod_out | output | 16 | Modifier of `sel_q` |
| cnt_zero | output | 1 | Counter of `sel_q` is zero |
| rd_data | output | 48 | Read value of `sel_q` |

## Verification
The assertions check four rules on every cycle. A written value lands in its target register. A post-update steps the counter and the modifier together. A whole-register copy reproduces the source. Nothing changes while `op_en` is low. The counter decrement is also checked at the point where it wraps from zero. Several behaviours can only be shown by the bench's sweep over every op code and many register pairs, compared against an arithmetic model. These are the exact values left in each field, the field masking of partial copies, the zero-extended read views, and the fact that register 0 and unrelated registers are left untouched.

// File: rtl/idx_pkg.sv
package idx_pkg;

  typedef enum logic [4:0] {
    OP_NOP   = 5'd0,
    OP_POST  = 5'd1,
    OP_MADD  = 5'd2,
    OP_MSUB  = 5'd3,
    OP_CNEG  = 5'd4,
    OP_CDEC  = 5'd5,
    OP_IP1   = 5'd6,
    OP_IM1   = 5'd7,
    OP_IP2   = 5'd8,
    OP_IM2   = 5'd9,
    OP_WC    = 5'd10,
    OP_WI    = 5'd11,
    OP_WM    = 5'd12,
    OP_WALL  = 5'd13,
    OP_RWC   = 5'd14,
    OP_RWI   = 5'd15,
    OP_RWM   = 5'd16,
    OP_CPC   = 5'd17,
    OP_CPI   = 5'd18,
    OP_CPM   = 5'd19,
    OP_CPCI  = 5'd20,
    OP_CPCM  = 5'd21,
    OP_CPIM  = 5'd22,
    OP_CPALL = 5'd23,
    OP_AC    = 5'd24,
    OP_AI    = 5'd25,
    OP_AM    = 5'd26,
    OP_AALL  = 5'd27
  } idx_op_e;

  typedef enum logic [1:0] {
    RF_CNT = 2'd0,
    RF_INC = 2'd1,
    RF_MOD = 2'd2,
    RF_ALL = 2'd3
  } idx_rf_e;

endpackage

// File: rtl/idx_update.sv
module idx_update
  import idx_pkg::*;
#(
  parameter int FW = 16,
  localparam int WW = 3 * FW
) (
  input  logic [4:0]    op,
  input  logic [WW-1:0] src,
  input  logic [WW-1:0] dst,
  input  logic [WW-1:0] wval,
  output logic          we,
  output logic          to_dst,
  output logic [WW-1:0] nxt
);

  logic [FW-1:0] sc, si, sm, dc, di, dm, w16;
  logic [FW-1:0] nc, ni, nm;
  logic [2:0]    cmask;   // {counter, increment, modifier}

  always_comb begin
    sc  = src[WW-1:2*FW];
    si  = src[2*FW-1:FW];
    sm  = src[FW-1:0];
    dc  = dst[WW-1:2*FW];
    di  = dst[2*FW-1:FW];
    dm  = dst[FW-1:0];
    w16 = wval[FW-1:0];
    nc = sc;
    ni = si;
    nm = sm;
    we = 1'b1;
    to_dst = 1'b0;
    cmask = 3'b000;
    case (op)
      OP_POST:  begin nc = sc - FW'(1); nm = sm + si; end
      OP_MADD:  nm = sm + si;
      OP_MSUB:  nm = sm - si;
      OP_CNEG:  nc = FW'(0) - sc;
      OP_CDEC:  nc = sc - FW'(1);
      OP_IP1:   ni = FW'(1);
      OP_IM1:   ni = FW'(0) - FW'(1);
      OP_IP2:   ni = FW'(2);
      OP_IM2:   ni = FW'(0) - FW'(2);
      OP_WC:    nc = w16;
      OP_WI:    ni = w16;
      OP_WM:    nm = w16;
      OP_WALL:  begin nc = wval[WW-1:2*FW]; ni = wval[2*FW-1:FW]; nm = wval[FW-1:0]; end
      OP_RWC:   begin nc = w16;    ni = FW'(1); nm = '0;  end
      OP_RWI:   begin nc = '0;     ni = w16;    nm = '0;  end
      OP_RWM:   begin nc = '0;     ni = FW'(1); nm = w16; end
      OP_CPC:   cmask = 3'b100;
      OP_CPI:   cmask = 3'b010;
      OP_CPM:   cmask = 3'b001;
      OP_CPCI:  cmask = 3'b110;
      OP_CPCM:  cmask = 3'b101;
      OP_CPIM:  cmask = 3'b011;
      OP_CPALL: cmask = 3'b111;
      OP_AC:    nc = sc + w16;
      OP_AI:    ni = si + w16;
      OP_AM:    nm = sm + w16;
      OP_AALL:  begin
        nc = sc + wval[WW-1:2*FW];
        ni = si + wval[2*FW-1:FW];
        nm = sm + wval[FW-1:0];
      end
      default:  we = 1'b0;
    endcase
    if (cmask != 3'b000) begin
      to_dst = 1'b1;
      nc = cmask[2] ? sc : dc;
      ni = cmask[1] ? si : di;
      nm = cmask[0] ? sm : dm;
    end
    nxt = {nc, ni, nm};
  end

endmodule

// File: rtl/idx_bank.sv
module idx_bank #(
  parameter int NREG = 16,
  parameter int FW   = 16,
  localparam int AW  = $clog2(NREG),
  localparam int WW  = 3 * FW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [WW-1:0]            wdata,
  output logic [NREG-1:0][WW-1:0]  regs
);

  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && waddr == AW'(g))
        regs[g] <= wdata;
    end
  end

  // R7: an accepted write to a non-zero register is visible one edge later
  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/idx_regfile.sv
module idx_regfile
  import idx_pkg::*;
#(
  parameter int NREG = 16,
  parameter int FW   = 16,
  localparam int AW  = $clog2(NREG),
  localparam int WW  = 3 * FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_en,
  input  logic [4:0]    op_code,
  input  logic [AW-1:0] sel_q,
  input  logic [AW-1:0] sel_qd,
  input  logic [WW-1:0] wr_data,
  input  logic [1:0]    rd_field,
  output logic [FW-1:0] mod_out,
  output logic          cnt_zero,
  output logic [WW-1:0] rd_data
);

  logic [NREG-1:0][WW-1:0] regs;
  logic [WW-1:0] src, dst, nxt;
  logic          upd_we, to_dst;
  logic [AW-1:0] tgt;
  logic          bank_we;

  assign src = regs[sel_q];
  assign dst = regs[sel_qd];

  idx_update #(.FW(FW)) u_update (
    .op     (op_code),
    .src    (src),
    .dst    (dst),
    .wval   (wr_data),
    .we     (upd_we),
    .to_dst (to_dst),
    .nxt    (nxt)
  );

  assign tgt     = to_dst ? sel_qd : sel_q;
  assign bank_we = op_en && upd_we && (tgt != '0);

  idx_bank #(.NREG(NREG), .FW(FW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bank_we),
    .waddr (tgt),
    .wdata (nxt),
    .regs  (regs)
  );

  assign mod_out  = src[FW-1:0];
  assign cnt_zero = (src[WW-1:2*FW] == '0);

  always_comb begin
    case (rd_field)
      RF_CNT:  rd_data = {{(2*FW){1'b0}}, src[WW-1:2*FW]};
      RF_INC:  rd_data = {{(2*FW){1'b0}}, src[2*FW-1:FW]};
      RF_MOD:  rd_data = {{(2*FW){1'b0}}, src[FW-1:0]};
      default: rd_data = src;
    endcase
  end

  // R3: post-update steps counter down and modifier by the increment together
  assert_post_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == OP_POST && sel_q != '0) |=>
      (regs[$past(sel_q)][WW-1:2*FW] == $past(src[WW-1:2*FW]) - FW'(1)) &&
      (regs[$past(sel_q)][FW-1:0] == $past(src[FW-1:0]) + $past(src[2*FW-1:FW])));

  // R5 / R11: decrementing a zero counter wraps to all ones
  assert_dec_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == OP_CDEC && sel_q != '0 && cnt_zero) |=>
      (regs[$past(sel_q)][WW-1:2*FW] == {FW{1'b1}}));

  // R9: full copy makes the destination equal to the source
  assert_copy_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == OP_CPALL && sel_qd != '0) |=>
      (regs[$past(sel_qd)] == $past(src)));

  // R12: no enable, no change
  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> $stable(regs));

endmodule

// File: tb/idx_regfile_bench.sv
module idx_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_en = 1'b0;
  logic [4:0]  op_code = '0;
  logic [3:0]  sel_q = '0;
  logic [3:0]  sel_qd = '0;
  logic [47:0] wr_data = '0;
  logic [1:0]  rd_field = 2'd3;
  logic [15:0] mod_out;
  logic        cnt_zero;
  logic [47:0] rd_data;

  always #5 clk = ~clk;

  idx_regfile u_idx_regfile (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_code(op_code),
    .sel_q(sel_q), .sel_qd(sel_qd), .wr_data(wr_data), .rd_field(rd_field),
    .mod_out(mod_out), .cnt_zero(cnt_zero), .rd_data(rd_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] mc [16];
  logic [15:0] mi [16];
  logic [15:0] mm [16];
  logic [31:0] rs = 32'h1234_5678;

  function automatic logic [31:0] step_rand(logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13;
    x ^= x >> 17;
    x ^= x << 5;
    return x;
  endfunction

  function automatic string req_of(int op);
    if (op == 1) return "R3";
    if (op == 2 || op == 3) return "R4";
    if (op == 4 || op == 5) return "R5";
    if (op >= 6 && op <= 9) return "R6";
    if (op >= 10 && op <= 13) return "R7";
    if (op >= 14 && op <= 16) return "R8";
    if (op >= 17 && op <= 23) return "R9";
    if (op >= 24 && op <= 27) return "R10";
    return "R12";
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected-state update from the requirement arithmetic
  task automatic model(input int op, input int q, input int qd, input logic [47:0] w);
    logic [15:0] c = mc[q], i = mi[q], m = mm[q], lo = w[15:0];
    int t = q;
    case (op)
      1: begin c = c - 16'd1; m = m + i; end
      2: m = m + i;
      3: m = m - i;
      4: c = 16'd0 - c;
      5: c = c - 16'd1;
      6: i = 16'd1;
      7: i = 16'hFFFF;
      8: i = 16'd2;
      9: i = 16'hFFFE;
      10: c = lo;
      11: i = lo;
      12: m = lo;
      13: begin c = w[47:32]; i = w[31:16]; m = w[15:0]; end
      14: begin c = lo; i = 16'd1; m = 16'd0; end
      15: begin c = 16'd0; i = lo; m = 16'd0; end
      16: begin c = 16'd0; i = 16'd1; m = lo; end
      24: c = c + lo;
      25: i = i + lo;
      26: m = m + lo;
      27: begin c = c + w[47:32]; i = i + w[31:16]; m = m + w[15:0]; end
      default: ;
    endcase
    if (op >= 17 && op <= 23) begin
      logic [2:0] k;
      t = qd;
      k = (op == 17) ? 3'b100 : (op == 18) ? 3'b010 : (op == 19) ? 3'b001 :
          (op == 20) ? 3'b110 : (op == 21) ? 3'b101 : (op == 22) ? 3'b011 : 3'b111;
      c = k[2] ? mc[q] : mc[qd];
      i = k[1] ? mi[q] : mi[qd];
      m = k[0] ? mm[q] : mm[qd];
    end
    if (t != 0 && op >= 1 && op <= 27) begin
      mc[t] = c; mi[t] = i; mm[t] = m;
    end
  endtask

  task automatic do_op(input int op, input int q, input int qd, input logic [47:0] w);
    @(negedge clk);
    op_en = 1'b1; op_code = 5'(op); sel_q = 4'(q); sel_qd = 4'(qd); wr_data = w;
    @(negedge clk);
    op_en = 1'b0;
    model(op, q, qd, w);
  endtask

  task automatic verify_all(input string req);
    for (int r = 0; r < 16; r++) begin
      sel_q = 4'(r); rd_field = 2'd3;
      #1;
      check((r == 0) ? "R2" : req, rd_data, {mc[r], mi[r], mm[r]});
      check("R11", {32'd0, mod_out}, {32'd0, mm[r]});
      check("R11", {47'd0, cnt_zero}, {47'd0, (mc[r] == 16'd0)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) begin mc[r] = '0; mi[r] = '0; mm[r] = '0; end
    repeat (3) @(negedge clk);
    // R12: reset clears everything
    verify_all("R12");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: whole and zero-extended single-field views
    do_op(13, 5, 0, 48'hA1B2_C3D4_E5F6);
    sel_q = 4'd5;
    rd_field = 2'd0; #1; check("R1", rd_data, 48'h0000_0000_A1B2);
    rd_field = 2'd1; #1; check("R1", rd_data, 48'h0000_0000_C3D4);
    rd_field = 2'd2; #1; check("R1", rd_data, 48'h0000_0000_E5F6);
    rd_field = 2'd3; #1; check("R1", rd_data, 48'hA1B2_C3D4_E5F6);

    // R12: op presented without enable changes nothing
    @(negedge clk);
    op_code = 5'd13; sel_q = 4'd5; wr_data = 48'h1; op_en = 1'b0;
    @(negedge clk);
    verify_all("R12");

    // R11 / R5: counter wraps below zero
    do_op(14, 3, 0, 48'h0);
    do_op(5, 3, 0, 48'h0);
    verify_all("R5");

    // near-exhaustive sweep: every op code across many register pairs
    for (int it = 0; it < 48; it++) begin
      for (int op = 0; op < 32; op++) begin
        logic [47:0] w;
        rs = step_rand(rs);
        w[47:24] = rs[23:0];
        rs = step_rand(rs);
        w[23:0] = rs[23:0];
        if (it % 5 == 0) w = '0;
        do_op(op, (it * 7 + op) % 16, (it * 5 + op * 3) % 16, w);
        verify_all(req_of(op));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule